// File: doc/BRIEF.md
# Serial Configuration Register Port

This block receives configuration words from a host over a three-wire, write-only serial link made of a shift clock, a data line and a latch strobe. It keeps them in a bank of configuration registers for a multichannel audio converter. The three wires are asynchronous to the block's own clock. They pass through synchronizer stages, and the block detects their edges. A data bit is taken on each rising edge of the shift clock, with the most significant bit first. A rising edge on the latch line then commits the word, but only if exactly one full frame of bits was shifted in since the previous latch edge. The frame is 16 bits wide: bits 15-12 carry the register address, bits 11-10 are reserved, and bits 9-0 carry the payload.

The bank holds three control registers and one volume register per channel. Their decoded fields are driven as plain level outputs to the rest of the converter: de-emphasis curve, serial data format, sample word width, power-down, interpolation ratio, per-channel mute, stereo replication, master-clock ratio, zero-flag polarity and the per-channel volume words. None of these outputs has a handshake. Each output holds its value until a committed write changes it. There is no read path.

The power-down control is deliberately delayed. The bit written into the first control register takes effect only at the next well-formed latch edge, so a host must send the power-down command twice to enter or leave power-down.

Top module: `sctl_port`

## Requirements
- R1: After reset, all control fields read zero. This means no de-emphasis, serial mode 000, word width 00, interpolation 00, power-down 0, no channel muted, replication off, master-clock ratio 00 and zero-flag polarity 0. Every volume word reads all ones.
- R2: Bits are taken MSB first, one per rising edge of `ser_clk`. A rising edge of `ser_latch` that follows exactly 16 clock edges since the previous latch edge commits the word. The register file then updates within a few cycles of the block clock.
- R3: A latch edge that follows fewer or more than 16 shift-clock edges changes no output.
- R4: A committed word whose address is in the range 1001 to 1111 changes no register output.
- R5: Address 0000 is control register I. Its fields are: bits 9-8 de-emphasis (00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz), bits 7-5 serial mode, bits 4-3 word width, and bits 1-0 interpolation ratio (00 8x, 01 2x, 10 4x). These fields appear on the outputs on the commit that writes them.
- R6: Bit 2 of control register I (power-down) reaches `power_down_o` only on the next well-formed latch edge after the one that stored it, whatever the address of that later word. Writing the same command twice therefore applies it.
- R7: Address 0001 is control register II. Payload bit k (k = 0..5) mutes channel k+1 when 1 and drives `mute_o[k]`. Payload bits 9-6 have no effect.
- R8: Address 1000 is control register III. Its fields are: bit 5 stereo replication, bits 4-3 master-clock ratio (00 256x, 01 512x, 10 768x), and bit 2 zero-flag polarity (1 = active low).
- R9: A word with nonzero reserved bits 11-10 is still committed normally.
- R10: Addresses 0010 through 0111 write the volume word of channels 1 through 6. The word appears on `vol_o[10*(n-1) +: 10]` for channel n. One write changes only that channel.
- R11: Every register output stays unchanged in every cycle in which no word is being committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Commit strobe; its rising edge ends a frame |
| deemph_o | output | 2 | De-emphasis curve select |
| ser_mode_o | output | 3 | Audio serial data format |
| word_width_o | output | 2 | Audio sample word width |
| power_down_o | output | 1 | Power-down request (delayed by one commit) |
| interp_o | output | 2 | Interpolation ratio |
| mute_o | output | NUM_VOL | Per-channel mute, bit k = channel k+1 |
| replicate_o | output | 1 | Copy channel pair 1 to the other pairs |
| mclk_ratio_o | output | 2 | Master-clock to sample-rate ratio |
| zflag_low_o | output | 1 | Zero flags active low when 1 |
| vol_o | output | NUM_VOL*VOL_W | Per-channel volume words, channel 1 in the low bits |

## Verification
The bench builds the block with six channels of 10-bit volume and with three synchronizer stages instead of the default two. The deeper synchronizer lengthens the delay from the serial pins to the committed register, and the bench's slow serial timing must allow for this. The 10-bit payload reaches every volume address and every field of the three control registers. With the full 4-bit address, random words also hit all seven reserved addresses. Randomly short and long frames, mixed with power-down commands, test the delayed power-down against ignored latch edges and against commits to other addresses.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int ADDR_W = 4;
  localparam int RSV_W  = 2;
  localparam int PAY_W  = 10;
  localparam int FRAME_W = ADDR_W + RSV_W + PAY_W;

  localparam logic [ADDR_W-1:0] ADR_CTL1    = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_CTL2    = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_VOLBASE = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_CTL3    = 4'h8;

  typedef struct packed {
    logic [1:0] deemph;
    logic [2:0] smode;
    logic [1:0] wwidth;
    logic       pd;
    logic [1:0] interp;
  } ctl1_t;

  typedef struct packed {
    logic [3:0] spare_hi;
    logic       repl;
    logic [1:0] ratio;
    logic       zpol;
    logic [1:0] spare_lo;
  } ctl3_t;

  localparam int SEL_CTL1 = 0;
  localparam int SEL_CTL2 = 1;
  localparam int SEL_CTL3 = 2;
  localparam int SEL_VOL0 = 3;
endpackage

// File: rtl/sctl_rx.sv
module sctl_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               ser_latch,
  output logic               commit_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] clk_s, dat_s, lat_s;
  logic clk_d, lat_d;
  logic clk_rise, lat_rise;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s <= '0;
      dat_s <= '0;
      lat_s <= '0;
      clk_d <= 1'b0;
      lat_d <= 1'b0;
    end else begin
      clk_s <= {clk_s[SYNC_STAGES-2:0], ser_clk};
      dat_s <= {dat_s[SYNC_STAGES-2:0], ser_dat};
      lat_s <= {lat_s[SYNC_STAGES-2:0], ser_latch};
      clk_d <= clk_s[SYNC_STAGES-1];
      lat_d <= lat_s[SYNC_STAGES-1];
    end
  end

  assign clk_rise = clk_s[SYNC_STAGES-1] & ~clk_d;
  assign lat_rise = lat_s[SYNC_STAGES-1] & ~lat_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      commit_o <= 1'b0;
      word_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      if (lat_rise) begin
        commit_o <= (cnt == CNT_FULL);
        word_o   <= shreg;
        cnt      <= '0;
      end else if (clk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], dat_s[SYNC_STAGES-1]};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
  import sctl_pkg::*;
#(
  parameter int NUM_VOL = 6
) (
  input  logic [FRAME_W-1:0]   word_i,
  output logic [PAY_W-1:0]     pay_o,
  output logic [NUM_VOL+2:0]   sel_o
);
  logic [ADDR_W-1:0] addr;

  assign addr  = word_i[FRAME_W-1 -: ADDR_W];
  assign pay_o = word_i[PAY_W-1:0];

  assign sel_o[SEL_CTL1] = (addr == ADR_CTL1);
  assign sel_o[SEL_CTL2] = (addr == ADR_CTL2);
  assign sel_o[SEL_CTL3] = (addr == ADR_CTL3);

  for (genvar g = 0; g < NUM_VOL; g++) begin : g_vsel
    assign sel_o[SEL_VOL0+g] = (addr == ADDR_W'(int'(ADR_VOLBASE) + g));
  end
endmodule

// File: rtl/sctl_bank.sv
module sctl_bank
  import sctl_pkg::*;
#(
  parameter int NUM_VOL = 6,
  parameter int VOL_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_i,
  input  logic [PAY_W-1:0]         pay_i,
  input  logic [NUM_VOL+2:0]       sel_i,
  output ctl1_t                    ctl1_o,
  output logic                     pd_act_o,
  output logic [NUM_VOL-1:0]       mute_o,
  output ctl3_t                    ctl3_o,
  output logic [NUM_VOL*VOL_W-1:0] vol_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_o   <= '0;
      pd_act_o <= 1'b0;
      mute_o   <= '0;
      ctl3_o   <= '0;
    end else if (commit_i) begin
      // The stored bit is the pending request; it moves out one commit later.
      pd_act_o <= ctl1_o.pd;
      if (sel_i[SEL_CTL1]) ctl1_o <= ctl1_t'(pay_i);
      if (sel_i[SEL_CTL2]) mute_o <= pay_i[NUM_VOL-1:0];
      if (sel_i[SEL_CTL3]) ctl3_o <= ctl3_t'(pay_i);
    end
  end

  for (genvar g = 0; g < NUM_VOL; g++) begin : g_vol
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vol_o[g*VOL_W +: VOL_W] <= '1;
      else if (commit_i && sel_i[SEL_VOL0+g])
        vol_o[g*VOL_W +: VOL_W] <= pay_i[VOL_W-1:0];
    end
  end
endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int NUM_VOL = 6,
  parameter int VOL_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     ser_latch,
  output logic [1:0]               deemph_o,
  output logic [2:0]               ser_mode_o,
  output logic [1:0]               word_width_o,
  output logic                     power_down_o,
  output logic [1:0]               interp_o,
  output logic [NUM_VOL-1:0]       mute_o,
  output logic                     replicate_o,
  output logic [1:0]               mclk_ratio_o,
  output logic                     zflag_low_o,
  output logic [NUM_VOL*VOL_W-1:0] vol_o
);
  logic               rx_commit;
  logic [FRAME_W-1:0] rx_word;
  logic [PAY_W-1:0]   dec_pay;
  logic [NUM_VOL+2:0] dec_sel;
  ctl1_t              ctl1;
  ctl3_t              ctl3;

  sctl_rx #(.SYNC_STAGES(SYNC_STAGES), .FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_latch(ser_latch), .commit_o(rx_commit), .word_o(rx_word)
  );

  sctl_decode #(.NUM_VOL(NUM_VOL)) u_dec (
    .word_i(rx_word), .pay_o(dec_pay), .sel_o(dec_sel)
  );

  sctl_bank #(.NUM_VOL(NUM_VOL), .VOL_W(VOL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit_i(rx_commit), .pay_i(dec_pay),
    .sel_i(dec_sel), .ctl1_o(ctl1), .pd_act_o(power_down_o),
    .mute_o(mute_o), .ctl3_o(ctl3), .vol_o(vol_o)
  );

  assign deemph_o     = ctl1.deemph;
  assign ser_mode_o   = ctl1.smode;
  assign word_width_o = ctl1.wwidth;
  assign interp_o     = ctl1.interp;
  assign replicate_o  = ctl3.repl;
  assign mclk_ratio_o = ctl3.ratio;
  assign zflag_low_o  = ctl3.zpol;
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk #(
  parameter int NUM_VOL = 6,
  parameter int VOL_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     commit,
  input logic [15:0]              word,
  input logic [1:0]               deemph_o,
  input logic [2:0]               ser_mode_o,
  input logic [1:0]               word_width_o,
  input logic                     power_down_o,
  input logic [1:0]               interp_o,
  input logic [NUM_VOL-1:0]       mute_o,
  input logic                     replicate_o,
  input logic [1:0]               mclk_ratio_o,
  input logic                     zflag_low_o,
  input logic [NUM_VOL*VOL_W-1:0] vol_o
);
  logic [NUM_VOL*VOL_W-1:0] vol_prev;
  logic [NUM_VOL-1:0]       vol_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vol_prev <= '1;
    else        vol_prev <= vol_o;
  end

  for (genvar g = 0; g < NUM_VOL; g++) begin : g_chg
    assign vol_chg[g] = (vol_prev[g*VOL_W +: VOL_W] != vol_o[g*VOL_W +: VOL_W]);
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(vol_o) && $stable(mute_o) && $stable(deemph_o) && $stable(ser_mode_o) && $stable(word_width_o) && $stable(interp_o) && $stable(power_down_o) && $stable(replicate_o) && $stable(mclk_ratio_o) && $stable(zflag_low_o))); // R11

  AST_RSV_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[15:12] > 4'h8) |=> ($stable(vol_o) && $stable(mute_o) && $stable(deemph_o) && $stable(interp_o) && $stable(replicate_o) && $stable(zflag_low_o))); // R4

  AST_CTL1_SAME_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[15:12] == 4'h0) |=> (deemph_o == $past(word[9:8]) && interp_o == $past(word[1:0]))); // R5

  AST_PD_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down_o) |-> $past(commit)); // R6

  AST_CTL3_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[15:12] == 4'h8) |=> (replicate_o == $past(word[5]) && mclk_ratio_o == $past(word[4:3]))); // R8

  AST_ONE_VOL_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vol_chg)); // R10

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R2
endmodule

bind sctl_port sctl_port_chk #(.NUM_VOL(NUM_VOL), .VOL_W(VOL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(rx_commit), .word(rx_word),
  .deemph_o(deemph_o), .ser_mode_o(ser_mode_o), .word_width_o(word_width_o),
  .power_down_o(power_down_o), .interp_o(interp_o), .mute_o(mute_o),
  .replicate_o(replicate_o), .mclk_ratio_o(mclk_ratio_o),
  .zflag_low_o(zflag_low_o), .vol_o(vol_o)
);

// File: tb/sctl_port_test.sv
module sctl_port_test;
  localparam int NV = 6;
  localparam int VW = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
  logic [1:0] deemph_o, word_width_o, interp_o, mclk_ratio_o;
  logic [2:0] ser_mode_o;
  logic power_down_o, replicate_o, zflag_low_o;
  logic [NV-1:0] mute_o;
  logic [NV*VW-1:0] vol_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [9:0] m_c1, m_c3;
  logic [NV-1:0] m_mute;
  logic [NV*VW-1:0] m_vol;
  logic m_pd;

  always #5 clk = ~clk;

  sctl_port #(.NUM_VOL(NV), .VOL_W(VW), .SYNC_STAGES(3)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_latch(ser_latch), .deemph_o(deemph_o), .ser_mode_o(ser_mode_o),
    .word_width_o(word_width_o), .power_down_o(power_down_o),
    .interp_o(interp_o), .mute_o(mute_o), .replicate_o(replicate_o),
    .mclk_ratio_o(mclk_ratio_o), .zflag_low_o(zflag_low_o), .vol_o(vol_o)
  );

  function automatic logic [15:0] mk(input logic [3:0] a, input logic [1:0] r, input logic [9:0] d);
    return {a, r, d};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_c1 = '0; m_c3 = '0; m_mute = '0; m_vol = '1; m_pd = 1'b0;
  endtask

  task automatic model_commit(input logic [15:0] w);
    m_pd = m_c1[2];
    case (w[15:12])
      4'h0: m_c1 = w[9:0];
      4'h1: m_mute = w[NV-1:0];
      4'h8: m_c3 = w[9:0];
      4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7:
        m_vol[(int'(w[15:12]) - 2)*VW +: VW] = w[9:0];
      default: ;
    endcase
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 16) ? w[15-i] : 1'b0;
      ser_clk = 1'b0; tick(HALF);
      ser_clk = 1'b1; tick(HALF);
    end
    ser_clk = 1'b0; tick(HALF);
    ser_latch = 1'b1; tick(HALF);
    ser_latch = 1'b0; tick(12);
    if (nbits == 16) model_commit(w);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R5 deemph"}, 64'(deemph_o), 64'(m_c1[9:8]));
    chk({tag, " R5 mode"}, 64'(ser_mode_o), 64'(m_c1[7:5]));
    chk({tag, " R5 width"}, 64'(word_width_o), 64'(m_c1[4:3]));
    chk({tag, " R5 interp"}, 64'(interp_o), 64'(m_c1[1:0]));
    chk({tag, " R6 pd"}, 64'(power_down_o), 64'(m_pd));
    chk({tag, " R7 mute"}, 64'(mute_o), 64'(m_mute));
    chk({tag, " R8 repl"}, 64'(replicate_o), 64'(m_c3[5]));
    chk({tag, " R8 ratio"}, 64'(mclk_ratio_o), 64'(m_c3[4:3]));
    chk({tag, " R8 zpol"}, 64'(zflag_low_o), 64'(m_c3[2]));
    chk({tag, " R10 vol"}, 64'(vol_o), 64'(m_vol));
  endtask

  initial begin
    void'($urandom(32'h1833));
    model_reset();
    tick(4);
    rst_n = 1'b1;
    tick(4);
    check_all("R1 reset");

    send(mk(4'h4, 2'b00, 10'h155), 16);
    check_all("R2 R10 vol ch3");
    chk("R10 ch3 slice", 64'(vol_o[2*VW +: VW]), 64'h155);

    send(mk(4'h2, 2'b00, 10'h000), 15);
    check_all("R3 short frame");
    send(mk(4'h2, 2'b00, 10'h000), 17);
    check_all("R3 long frame");

    send(mk(4'hA, 2'b00, 10'h000), 16);
    check_all("R4 reserved addr");

    send(mk(4'h0, 2'b00, 10'b11_011_10_1_10), 16);
    chk("R5 fields on own commit", 64'(deemph_o), 64'h3);
    chk("R6 pd not yet", 64'(power_down_o), 64'h0);
    send(mk(4'h0, 2'b00, 10'b11_011_10_1_10), 16);
    chk("R6 pd after second", 64'(power_down_o), 64'h1);
    check_all("R6 double write");

    send(mk(4'h1, 2'b00, 10'b1111_100101), 16);
    chk("R7 mute bits", 64'(mute_o), 64'h25);
    send(mk(4'h8, 2'b00, 10'b0000_1_10_1_00), 16);
    check_all("R8 ctl3");
    send(mk(4'h7, 2'b11, 10'h0AB), 16);
    chk("R9 rsv bits accepted", 64'(vol_o[5*VW +: VW]), 64'h0AB);

    for (int k = 0; k < 250; k++) begin
      logic [3:0] a;
      int nb;
      int r;
      r = int'($urandom % 20);
      a = (r < 4) ? 4'h0 : 4'($urandom % 16);
      nb = (r == 19) ? 15 : (r == 18) ? 17 : 16;
      send(mk(a, 2'($urandom % 4), 10'($urandom % 1024)), nb);
      check_all("R2 R3 R4 R11 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule